// File: doc/BRIEF.md
# Memory-controller performance counter bank

This block watches a memory controller and counts what it does. It holds four counters. Counter 0 always counts clock cycles. Counters 1 to 3 each count one event, which software selects by a code. The memory controller supplies its events as a vector of single-cycle strobes, and the event code is the index into that vector. Software reaches the block through a flat 32-bit register interface. Each counter has a control register and a read-only value register. Reads complete combinationally in the cycle they are addressed.

The cycle counter is the master of the bank. Event counters advance only while the cycle counter is enabled and has not overflowed. When the cycle counter wraps, the whole bank freezes and the interrupt line rises. Software can then read every counter and restart the bank. A preset field loads bits 23:16 of a counter when it is cleared, so the cycle counter can be made to wrap early. An event counter that wraps sets its own flag and raises no interrupt. A build parameter selects whether that counter then stops or keeps counting.

Top module: `ddr_perf_counter_bank`

## Requirements
- R1: While its enable bit is 1 and its overflow flag is 0, counter 0 increments by one on every clock, whatever its event-select field holds.
- R2: Counter n (1 to 3) increments once in each cycle in which `evt_in[code]` is high, where code is its event-select field and lies in 1..NUM_EVT-1. With code 0 or a code of NUM_EVT and above, the counter counts nothing.
- R3: The control register of counter n sits at byte address 4*n and its value register at 0x20+4*n. The control fields are: bit 0 overflow flag (read-only), bit 1 clear, bit 2 enable, bits 23:16 preset, bits 31:24 event select. Other bits read as 0. A read returns its data in the same cycle. Unmapped addresses read 0. Writes to value registers, and to the overflow bit, change nothing.
- R4: A write that sets the clear bit while the stored clear bit is 0 loads the counter and zeroes its overflow flag. Writing 1 when the stored bit is already 1 leaves the count untouched.
- R5: The value loaded by a clear holds the preset field of that same write in bits 23:16 and 0 in every other bit.
- R6: A counter whose enable bit is 0 holds its value. No event counter advances while counter 0 is disabled.
- R7: When counter 0 steps from all-ones, it wraps to 0 and sets its overflow flag. From the next cycle on, every counter holds its value.
- R8: `irq` is high while counter 0 has its overflow flag set and its enable bit set. It goes low the cycle after a control-0 write that clears the enable bit or makes a clear edge.
- R9: An event counter that steps from all-ones wraps to 0, sets its overflow flag and leaves `irq` unchanged. With STOP_ON_OVF=1 it then holds until cleared. With STOP_ON_OVF=0 it keeps counting.
- R10: After reset every control and value register reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| evt_in | input | NUM_EVT | Event strobes, indexed by event code |
| irq | output | 1 | Cycle-counter overflow interrupt |

## Verification
A wrong step condition or a lost clear edge shows up as a wrong count on the very next read of a value register. A wrong cycle-counter overflow flag shows up on `irq` in the same cycle it goes wrong, so the bench compares `irq` with its model on every clock. A freeze that fails to take hold makes the event counters drift once the cycle counter has wrapped, and reads then expose it. A stop or wrap mode that behaves wrongly appears as a nonzero or frozen value after an event counter wraps. Two instances built with opposite mode settings run side by side for this.

// File: rtl/perf_bank_pkg.sv
`timescale 1ns/1ps
// Shared register layout constants and control-register type for the
// performance counter bank. Assumes a 32-bit register data path.
package perf_bank_pkg;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 8;
    localparam int FIELD_W  = 8;
    localparam int BIT_OVF  = 0;
    localparam int BIT_CLR  = 1;
    localparam int BIT_EN   = 2;
    localparam int PRE_LSB  = 16;
    localparam int SEL_LSB  = 24;
    localparam logic [ADDR_W-1:0] VAL_BASE = 8'h20;

    typedef struct packed {
        logic [FIELD_W-1:0] sel;
        logic [FIELD_W-1:0] pre;
        logic               en;
        logic               clr;
    } ctl_t;
endpackage

// File: rtl/perf_ctl_reg.sv
`timescale 1ns/1ps
// Control register of one counter. Holds the select, preset, enable and
// clear fields, and flags a clear edge (clear written 1 while stored 0).
// Assumes wr_hit is already qualified by the address decode.
module perf_ctl_reg
    import perf_bank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic [REG_W-1:0]   wdata,
    output ctl_t               ctl,
    output logic               clr_rise,
    output logic [FIELD_W-1:0] pre_new
);
    // Clear edge and the preset value that travels with it
    assign clr_rise = wr_hit & wdata[BIT_CLR] & ~ctl.clr;
    assign pre_new  = wdata[PRE_LSB +: FIELD_W];

    // Store the writable control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr_hit) begin
            ctl.sel <= wdata[SEL_LSB +: FIELD_W];
            ctl.pre <= wdata[PRE_LSB +: FIELD_W];
            ctl.en  <= wdata[BIT_EN];
            ctl.clr <= wdata[BIT_CLR];
        end
    end
endmodule

// File: rtl/perf_event_mux.sv
`timescale 1ns/1ps
// Picks the event strobe named by an event code. Code 0 and codes at or
// above NUM_EVT select nothing. Assumes NUM_EVT <= 256.
module perf_event_mux #(
    parameter int NUM_EVT = 64
) (
    input  logic [7:0]         code,
    input  logic [NUM_EVT-1:0] evt,
    output logic               hit
);
    // Compare the code against each strobe index
    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < NUM_EVT; k++) begin
            if (code == 8'(k)) hit = evt[k] & (k != 0);
        end
    end
endmodule

// File: rtl/perf_counter.sv
`timescale 1ns/1ps
// One counter with an overflow flag. A clear edge loads the preset into
// bits 23:16. Assumes CNT_W >= 24 and that step_req is already gated
// by enable, event and bank run state.
module perf_counter
    import perf_bank_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter bit STOP_ON_OVF = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_rise,
    input  logic [FIELD_W-1:0] pre_new,
    input  logic               step_req,
    output logic [CNT_W-1:0]   cnt,
    output logic               ovf
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] preset;
    logic             step;

    // Build the clear value with the preset in bits 23:16
    always_comb begin
        preset = '0;
        preset[PRE_LSB +: FIELD_W] = pre_new;
    end

    // An overflowed counter holds in stop mode
    assign step = step_req & ~(STOP_ON_OVF & ovf);

    // Count, wrap and flag overflow; a clear edge wins over a step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (clr_rise) begin
            cnt <= preset;
            ovf <= 1'b0;
        end else if (step) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_MAX) ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/ddr_perf_counter_bank.sv
`timescale 1ns/1ps
// Performance counter bank. Counter 0 counts cycles and governs the
// bank; the other counters count selected event strobes. Overflow of
// counter 0 freezes all counters and raises irq. Assumes CNT_W in
// 24..32 and NUM_CTR <= 8, so the control and value windows do not overlap.
module ddr_perf_counter_bank
    import perf_bank_pkg::*;
#(
    parameter int NUM_CTR     = 4,
    parameter int CNT_W       = 32,
    parameter int NUM_EVT     = 64,
    parameter bit STOP_ON_OVF = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               irq
);
    localparam int CTL_PAD = PRE_LSB - BIT_EN - 1;

    ctl_t                     ctl_arr [NUM_CTR];
    logic [NUM_CTR-1:0]       clr_rise;
    logic [FIELD_W-1:0]       pre_new [NUM_CTR];
    logic [NUM_CTR-1:0]       hit_vec;
    logic [NUM_CTR-1:0]       step_req;
    logic [NUM_CTR-1:0]       en_vec;
    logic [NUM_CTR-1:0]       clr_vec;
    logic [NUM_CTR-1:0]       ovf_vec;
    logic [NUM_CTR*8-1:0]     sel_flat;
    logic [NUM_CTR*CNT_W-1:0] cnt_flat;
    logic                     run;

    // The bank runs while the cycle counter is enabled and not overflowed
    assign run = ctl_arr[0].en & ~ovf_vec[0];
    assign irq = ctl_arr[0].en & ovf_vec[0];

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        perf_ctl_reg u_ctl (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (reg_wr && (reg_addr == ADDR_W'(4 * i))),
            .wdata    (reg_wdata),
            .ctl      (ctl_arr[i]),
            .clr_rise (clr_rise[i]),
            .pre_new  (pre_new[i])
        );

        if (i == 0) begin : g_cyc
            // The cycle counter steps on every running clock
            assign hit_vec[i]  = 1'b1;
            assign step_req[i] = run;
        end else begin : g_evt
            perf_event_mux #(.NUM_EVT(NUM_EVT)) u_mux (
                .code (ctl_arr[i].sel),
                .evt  (evt_in),
                .hit  (hit_vec[i])
            );
            // Event counters need the bank running and their own enable
            assign step_req[i] = run & ctl_arr[i].en & hit_vec[i];
        end

        perf_counter #(
            .CNT_W       (CNT_W),
            .STOP_ON_OVF (STOP_ON_OVF)
        ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_rise (clr_rise[i]),
            .pre_new  (pre_new[i]),
            .step_req (step_req[i]),
            .cnt      (cnt_flat[i*CNT_W +: CNT_W]),
            .ovf      (ovf_vec[i])
        );

        assign en_vec[i]          = ctl_arr[i].en;
        assign clr_vec[i]         = ctl_arr[i].clr;
        assign sel_flat[i*8 +: 8] = ctl_arr[i].sel;
    end

    // Same-cycle register read decode
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (reg_addr == ADDR_W'(4 * i)) begin
                reg_rdata = {ctl_arr[i].sel, ctl_arr[i].pre, {CTL_PAD{1'b0}},
                             ctl_arr[i].en, ctl_arr[i].clr, ovf_vec[i]};
            end
            if (reg_addr == VAL_BASE + ADDR_W'(4 * i)) begin
                reg_rdata = REG_W'(cnt_flat[i*CNT_W +: CNT_W]);
            end
        end
    end
endmodule

// File: rtl/perf_bank_checker.sv
`timescale 1ns/1ps
// Property checker for the counter bank, bound to the top module.
// Observes the register port, irq and the per-counter state.
module perf_bank_checker #(
    parameter int NUM_CTR     = 4,
    parameter int CNT_W       = 32,
    parameter int NUM_EVT     = 64,
    parameter bit STOP_ON_OVF = 1'b1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr,
    input logic [7:0]               addr,
    input logic [31:0]              wdata,
    input logic                     irq,
    input logic [NUM_CTR-1:0]       en_vec,
    input logic [NUM_CTR-1:0]       clr_vec,
    input logic [NUM_CTR-1:0]       ovf_vec,
    input logic [NUM_CTR*8-1:0]     sel_flat,
    input logic [NUM_CTR*CNT_W-1:0] cnt_flat
);
    logic [CNT_W-1:0] pre_w;
    logic [CNT_W-1:0] cnt0;

    // Clear value implied by the write data
    always_comb begin
        pre_w = '0;
        pre_w[16 +: 8] = wdata[23:16];
    end
    assign cnt0 = cnt_flat[CNT_W-1:0];

    assert_cycle_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec[0] && !ovf_vec[0] && !(wr && addr == 8'h00))
        |=> cnt0 == CNT_W'($past(cnt0) + 1'b1));

    assert_cycle_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_vec[0] && !wr) |=> $stable(cnt_flat));

    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_vec[0] && !wr) |=> $stable(cnt_flat));

    assert_irq_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == 8'h00 && !wdata[2]) |=> !irq);

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
        assert_clear_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && addr == 8'(4 * i) && wdata[1] && !clr_vec[i])
            |=> cnt_flat[i*CNT_W +: CNT_W] == $past(pre_w));

        if (i > 0) begin : g_evt
            assert_dead_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
                ((sel_flat[i*8 +: 8] == 8'h00 || int'(sel_flat[i*8 +: 8]) >= NUM_EVT)
                 && !(wr && addr == 8'(4 * i)))
                |=> $stable(cnt_flat[i*CNT_W +: CNT_W]));

            if (STOP_ON_OVF) begin : g_stop
                assert_stop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
                    (ovf_vec[i] && !(wr && addr == 8'(4 * i)))
                    |=> $stable(cnt_flat[i*CNT_W +: CNT_W]));
            end
        end
    end
endmodule

bind ddr_perf_counter_bank perf_bank_checker #(
    .NUM_CTR     (NUM_CTR),
    .CNT_W       (CNT_W),
    .NUM_EVT     (NUM_EVT),
    .STOP_ON_OVF (STOP_ON_OVF)
) u_perf_bank_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .irq      (irq),
    .en_vec   (en_vec),
    .clr_vec  (clr_vec),
    .ovf_vec  (ovf_vec),
    .sel_flat (sel_flat),
    .cnt_flat (cnt_flat)
);

// File: tb/ddr_perf_counter_bank_bench.sv
`timescale 1ns/1ps
// Bench: two instances (stop mode and wrap mode) against a behavioural
// model that steps on every clock; irq is compared every cycle.
module ddr_perf_counter_bank_bench;
    localparam int CW = 24;
    localparam logic [31:0] MASK = 32'h00FF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [63:0] evt = '0;
    logic [31:0] rd_s, rd_w;
    logic        irq_s, irq_w;
    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    ddr_perf_counter_bank #(.CNT_W(CW), .STOP_ON_OVF(1'b1)) u_ddr_perf_counter_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd_s), .evt_in(evt), .irq(irq_s));

    ddr_perf_counter_bank #(.CNT_W(CW), .STOP_ON_OVF(1'b0)) u_ddr_perf_counter_bank_wrap (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd_w), .evt_in(evt), .irq(irq_w));

    // Model state: index 0 is the stop-mode instance, 1 the wrap-mode one
    logic [31:0] mval [2][4];
    logic [7:0]  mpre [2][4];
    logic [7:0]  msel [2][4];
    bit          men  [2][4];
    bit          mclr [2][4];
    bit          movf [2][4];
    bit          run, hit, inc;

    always @(posedge clk) begin
        for (int m = 0; m < 2; m++) begin
            if (!rst_n) begin
                for (int i = 0; i < 4; i++) begin
                    mval[m][i] = 0; mpre[m][i] = 0; msel[m][i] = 0;
                    men[m][i] = 0; mclr[m][i] = 0; movf[m][i] = 0;
                end
            end else begin
                run = men[m][0] && !movf[m][0];
                for (int i = 0; i < 4; i++) begin
                    hit = (msel[m][i] != 0 && msel[m][i] < 64) ? evt[msel[m][i]] : 1'b0;
                    if (i == 0) inc = run;
                    else inc = run && men[m][i] && hit && !(m == 0 && movf[m][i]);
                    if (inc) begin
                        if (mval[m][i] == MASK) begin
                            mval[m][i] = 0; movf[m][i] = 1;
                        end else mval[m][i] = mval[m][i] + 1;
                    end
                    if (reg_wr && reg_addr == 8'(4 * i)) begin
                        if (reg_wdata[1] && !mclr[m][i]) begin
                            mval[m][i] = {8'h00, reg_wdata[23:16], 16'h0000};
                            movf[m][i] = 0;
                        end
                        men[m][i]  = reg_wdata[2];
                        mclr[m][i] = reg_wdata[1];
                        mpre[m][i] = reg_wdata[23:16];
                        msel[m][i] = reg_wdata[31:24];
                    end
                end
            end
        end
    end

    function automatic logic [31:0] mread(int m, logic [7:0] a);
        for (int i = 0; i < 4; i++) begin
            if (a == 8'(4 * i))
                return {msel[m][i], mpre[m][i], 13'b0, men[m][i], mclr[m][i], movf[m][i]};
            if (a == 8'h20 + 8'(4 * i)) return mval[m][i];
        end
        return 32'h0;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ctl(logic [7:0] sel, logic [7:0] pre, bit en, bit clr);
        return {sel, pre, 13'b0, en, clr, 1'b0};
    endfunction

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Read one address from both instances and compare against the model
    task automatic rd_chk(logic [7:0] a, string req);
        reg_addr = a;
        #1;
        check(req, rd_s, mread(0, a));
        check(req, rd_w, mread(1, a));
    endtask

    // Read one address and compare both instances with a literal value
    task automatic rd_lit(logic [7:0] a, logic [31:0] exp, string req);
        reg_addr = a;
        #1;
        check(req, rd_s, exp);
        check(req, rd_w, exp);
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    // irq compared with the model on every clock (R8, R7)
    always @(negedge clk) begin
        if (rst_n) begin
            check("R8 irq stop", {31'b0, irq_s}, {31'b0, men[0][0] && movf[0][0]});
            check("R8 irq wrap", {31'b0, irq_w}, {31'b0, men[1][0] && movf[1][0]});
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] hold_s, hold_w;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        // R10 reset state
        for (int i = 0; i < 4; i++) begin
            rd_lit(8'(4 * i), 32'h0, "R10 ctl reset");
            rd_lit(8'h20 + 8'(4 * i), 32'h0, "R10 value reset");
        end
        check("R10 irq reset", {31'b0, irq_s | irq_w}, 32'h0);

        wr(8'h04, ctl(8'h04, 8'h00, 1, 1));
        wr(8'h08, ctl(8'h37, 8'h00, 1, 1));
        wr(8'h0C, ctl(8'h7F, 8'h00, 1, 1));
        // R6: event counters idle while counter 0 is disabled
        evt = '1;
        cycles(20);
        evt = '0;
        rd_lit(8'h24, 32'h0, "R6 no count without cycle counter");
        rd_lit(8'h28, 32'h0, "R6 no count without cycle counter");

        // R1, R2: cycle counting and event patterns
        wr(8'h00, ctl(8'h00, 8'h00, 1, 1));
        for (int k = 0; k < 200; k++) begin
            evt = '0;
            evt[4]  = (k % 3 == 0);
            evt[55] = (k % 5 != 1);
            evt[0]  = 1'b1;
            evt[63] = 1'b1;
            @(negedge clk);
        end
        evt = '0;
        rd_chk(8'h20, "R1 cycle count");
        rd_lit(8'h24, 32'd67, "R2 read-access count");
        rd_lit(8'h28, 32'd160, "R2 refresh count");
        rd_lit(8'h2C, 32'd0, "R2 unknown code counts nothing");

        // R2: code 0 on an event counter counts nothing
        wr(8'h0C, ctl(8'h00, 8'h00, 1, 1));
        evt[0] = 1'b1;
        cycles(10);
        evt = '0;
        rd_lit(8'h2C, 32'd0, "R2 code 0 counts nothing");

        // R3: unmapped read, value write ignored, overflow bit read-only
        rd_lit(8'h10, 32'h0, "R3 unmapped read");
        wr(8'h24, 32'h000A_BCDE);
        rd_lit(8'h24, 32'd67, "R3 value write ignored");
        wr(8'h0C, ctl(8'h00, 8'h00, 1, 1) | 32'h1);
        rd_lit(8'h0C, ctl(8'h00, 8'h00, 1, 1), "R3 overflow bit not writable");

        // R6: disabled counter holds
        wr(8'h04, ctl(8'h04, 8'h00, 0, 1));
        evt[4] = 1'b1;
        cycles(10);
        evt = '0;
        rd_lit(8'h24, 32'd67, "R6 disabled counter holds");

        // R4: clear only on a 0-to-1 edge
        wr(8'h08, ctl(8'h37, 8'h00, 1, 1));
        rd_lit(8'h28, 32'd160, "R4 clear without edge keeps count");
        wr(8'h08, 32'h0);
        wr(8'h08, ctl(8'h37, 8'h00, 1, 1));
        rd_lit(8'h28, 32'd0, "R4 clear edge zeroes count");

        // R5 and R9: preset on an event counter, then overflow
        wr(8'h08, 32'h0);
        wr(8'h08, ctl(8'h05, 8'hFF, 1, 1));
        rd_lit(8'h28, 32'h00FF_0000, "R5 preset loaded");
        evt[5] = 1'b1;
        cycles(65539);
        evt = '0;
        reg_addr = 8'h08; #1;
        check("R9 event overflow flag stop", rd_s & 32'h1, 32'h1);
        check("R9 event overflow flag wrap", rd_w & 32'h1, 32'h1);
        check("R9 no irq from event counter", {31'b0, irq_s | irq_w}, 32'h0);
        reg_addr = 8'h28; #1;
        check("R9 stop mode holds", rd_s, 32'd0);
        check("R9 wrap mode keeps counting", rd_w, 32'd3);
        rd_chk(8'h28, "R9 model match");

        // R7, R5: cycle counter preset and overflow freeze
        wr(8'h00, 32'h0);
        wr(8'h00, ctl(8'h00, 8'hFF, 1, 1));
        rd_lit(8'h20, 32'h00FF_0000, "R5 cycle preset loaded");
        wr(8'h04, ctl(8'h04, 8'h00, 1, 1));
        evt[4] = 1'b1;
        cycles(65545);
        check("R7 irq raised stop", {31'b0, irq_s}, 32'h1);
        check("R7 irq raised wrap", {31'b0, irq_w}, 32'h1);
        rd_lit(8'h20, 32'h0, "R7 cycle counter wrapped to 0");
        reg_addr = 8'h24; #1;
        hold_s = rd_s; hold_w = rd_w;
        cycles(20);
        reg_addr = 8'h24; #1;
        check("R7 event counter frozen stop", rd_s, hold_s);
        check("R7 event counter frozen wrap", rd_w, hold_w);
        rd_chk(8'h24, "R7 model match");
        evt = '0;

        // R8: irq release by disable and by clear edge
        wr(8'h00, ctl(8'h00, 8'hFF, 0, 1));
        check("R8 irq low after disable", {31'b0, irq_s | irq_w}, 32'h0);
        wr(8'h00, ctl(8'h00, 8'hFF, 1, 1));
        check("R8 irq back without clear edge", {31'b0, irq_s & irq_w}, 32'h1);
        wr(8'h00, 32'h0);
        wr(8'h00, ctl(8'h00, 8'h00, 1, 1));
        check("R8 irq low after clear edge", {31'b0, irq_s | irq_w}, 32'h0);
        rd_lit(8'h20, 32'h0, "R4 cycle counter cleared");

        for (int i = 0; i < 4; i++) begin
            rd_chk(8'(4 * i), "R3 final ctl");
            rd_chk(8'h20 + 8'(4 * i), "R3 final value");
        end
        finish_run();
    end
endmodule